// File: doc/BRIEF.md
# Loop-Bounded Program Counter Sequencer

This block sequences the configuration memory of one processing element. It keeps a program counter together with a pair of hardware loop bounds, a loop-start and a loop-end register. On every stepped cycle the counter moves forward by one. When the counter already sits on the loop-end entry, the next stepped cycle sends it back to loop-start. A branch configuration does two things at once: it redirects the counter and it reprograms both loop bounds. The branch may name an explicit target. Without one, the counter lands on the new loop-start value.

The surrounding processing element decodes the current configuration word and presents the branch fields together with a step strobe. The sequencer answers one clock later with three things: the new counter, a one-cycle pulse that clears the element's predicate register after a branch, and a one-cycle pulse that tells the address unit to advance when the stepped word carries the address-trigger flag. The counter is 5 bits wide by default, which addresses a 32-entry configuration memory. In the full configuration word the branch target sits in bits 49 to 45 and the address-trigger flag sits in bit 59. The decoder outside this block extracts both.

Top module: `loop_pc_sequencer`

## Requirements
- R1: While reset is held and immediately after it, `pc_o`, `pred_clr_o` and `agu_step_o` are 0. Both loop bounds are 0, so stepped non-branch cycles keep `pc_o` at 0 until a branch executes.
- R2: In a cycle with `step_i` low, `pc_o` keeps its value on the next cycle and both pulses are 0, whatever the branch fields carry.
- R3: A stepped non-branch cycle with `pc_o` not equal to loop-end gives `pc_o` + 1, modulo 2^PC_W, on the next cycle (31 goes to 0 at the default width).
- R4: A stepped non-branch cycle with `pc_o` equal to loop-end gives loop-start on the next cycle.
- R5: A stepped branch with `jmp_has_dst_i` = 1 gives `jmp_dst_i` on `pc_o` on the next cycle.
- R6: A stepped branch with `jmp_has_dst_i` = 0 gives the `loop_start_i` field on `pc_o` on the next cycle.
- R7: A stepped branch loads loop-start from `loop_start_i` and loop-end from `loop_end_i`. Later R3 and R4 decisions use these new values.
- R8: `pred_clr_o` is 1 for exactly the one cycle that follows a stepped branch, and is 0 at all other times.
- R9: `agu_step_o` is 1 for exactly the one cycle that follows a stepped cycle with `agu_trig_i` = 1, for branches and non-branches alike. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Current configuration word executes this cycle |
| is_jump_i | input | 1 | Current word is a branch |
| jmp_has_dst_i | input | 1 | Branch carries an explicit target |
| jmp_dst_i | input | PC_W | Branch target (word bits 49:45) |
| loop_start_i | input | PC_W | New loop-start value carried by the branch |
| loop_end_i | input | PC_W | New loop-end value carried by the branch |
| agu_trig_i | input | 1 | Address-trigger flag of the current word (word bit 59) |
| pc_o | output | PC_W | Program counter |
| pred_clr_o | output | 1 | Predicate clear pulse |
| agu_step_o | output | 1 | Address unit advance pulse |

## Verification
Every result of this block is registered. The counter, the predicate-clear pulse and the address-advance pulse all reflect the inputs of a stepped cycle exactly one clock edge later, and a counter that is not stepped holds its value. The bench drives each cycle's inputs on the falling edge. It predicts the three outputs from its own counter and loop-bound model, then compares them on the next falling edge, so every comparison lands one rising edge after its stimulus. The reset values are compared before any rising edge sees `rst_n` high.

// File: rtl/lps_pkg.sv
// Package: shared constants and types for the loop-bounded PC sequencer.
// Assumes: the configuration memory depth is a power of two addressed by the PC.
package lps_pkg;

    // Default PC width; 5 bits address 32 configuration entries.
    localparam int unsigned PC_W_DEF = 5;

    // Source chosen for the next program counter value.
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_INC  = 2'd1,
        SRC_WRAP = 2'd2,
        SRC_JUMP = 2'd3
    } pc_src_e;

endpackage : lps_pkg

// File: rtl/lps_bound_regs.sv
// Module: holds the loop-start and loop-end registers.
// Does:    both bounds reload together from the branch fields when load_i is high.
// Assumes: load_i is already qualified by the step strobe.
module lps_bound_regs #(
    parameter int unsigned PC_W = lps_pkg::PC_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [PC_W-1:0] start_i,
    input  logic [PC_W-1:0] end_i,
    output logic [PC_W-1:0] start_q,
    output logic [PC_W-1:0] end_q
);

    // Purpose: clear the bounds on reset and reload them on a stepped branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (load_i) begin
            start_q <= start_i;
            end_q   <= end_i;
        end
    end

endmodule : lps_bound_regs

// File: rtl/lps_next_pc.sv
// Module: combinational next-PC selector.
// Does:    picks hold, increment, wrap to loop-start, or branch target.
// Assumes: the increment wraps modulo 2**PC_W, and a branch takes priority over
//          the loop-end test.
module lps_next_pc #(
    parameter int unsigned PC_W = lps_pkg::PC_W_DEF
) (
    input  logic                 step_i,
    input  logic                 is_jump_i,
    input  logic                 has_dst_i,
    input  logic [PC_W-1:0]      dst_i,
    input  logic [PC_W-1:0]      new_start_i,
    input  logic [PC_W-1:0]      pc_q,
    input  logic [PC_W-1:0]      start_q,
    input  logic [PC_W-1:0]      end_q,
    output lps_pkg::pc_src_e     src_o,
    output logic [PC_W-1:0]      pc_nxt_o
);

    logic [PC_W-1:0] jump_tgt;
    logic [PC_W-1:0] pc_inc;
    logic            at_end;

    // Purpose: a branch without a named target lands on its own new loop start.
    always_comb jump_tgt = has_dst_i ? dst_i : new_start_i;

    // Purpose: compute the plain successor and the loop-end match.
    always_comb begin
        pc_inc = pc_q + PC_W'(1);
        at_end = (pc_q == end_q);
    end

    // Purpose: classify this cycle's counter update.
    always_comb begin
        if (!step_i)        src_o = lps_pkg::SRC_HOLD;
        else if (is_jump_i) src_o = lps_pkg::SRC_JUMP;
        else if (at_end)    src_o = lps_pkg::SRC_WRAP;
        else                src_o = lps_pkg::SRC_INC;
    end

    // Purpose: steer the chosen value onto the next-PC bus.
    always_comb begin
        unique case (src_o)
            lps_pkg::SRC_HOLD: pc_nxt_o = pc_q;
            lps_pkg::SRC_INC:  pc_nxt_o = pc_inc;
            lps_pkg::SRC_WRAP: pc_nxt_o = start_q;
            lps_pkg::SRC_JUMP: pc_nxt_o = jump_tgt;
            default:           pc_nxt_o = pc_q;
        endcase
    end

endmodule : lps_next_pc

// File: rtl/lps_strobe_regs.sv
// Module: registers the single-cycle side-effect pulses of a stepped word.
// Does:    predicate clear after a stepped branch, address advance after a
//          stepped word whose trigger flag is set.
// Assumes: inputs are valid when step_i is high and ignored otherwise.
module lps_strobe_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic is_jump_i,
    input  logic agu_trig_i,
    output logic pred_clr_q,
    output logic agu_step_q
);

    // Purpose: each pulse lasts one cycle because it is recomputed every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_clr_q <= 1'b0;
            agu_step_q <= 1'b0;
        end else begin
            pred_clr_q <= step_i & is_jump_i;
            agu_step_q <= step_i & agu_trig_i;
        end
    end

endmodule : lps_strobe_regs

// File: rtl/loop_pc_sequencer.sv
// Module: per-PE program counter sequencer with hardware loop bounds.
// Does:    steps a PC through the configuration memory, wraps from loop-end to
//          loop-start, and lets a branch both redirect the PC and reload the bounds.
// Assumes: decoded fields arrive with step_i; all outputs are registered.
module loop_pc_sequencer #(
    parameter int unsigned PC_W = lps_pkg::PC_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            is_jump_i,
    input  logic            jmp_has_dst_i,
    input  logic [PC_W-1:0] jmp_dst_i,
    input  logic [PC_W-1:0] loop_start_i,
    input  logic [PC_W-1:0] loop_end_i,
    input  logic            agu_trig_i,
    output logic [PC_W-1:0] pc_o,
    output logic            pred_clr_o,
    output logic            agu_step_o
);

    localparam int unsigned DEPTH = 1 << PC_W;

    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  pc_nxt;
    logic [PC_W-1:0]  ls_q;
    logic [PC_W-1:0]  le_q;
    logic             bound_load;
    lps_pkg::pc_src_e pc_src;

    // Purpose: the bounds reload only on a branch that actually executes.
    always_comb bound_load = step_i & is_jump_i;

    lps_bound_regs #(.PC_W(PC_W)) u_bounds (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (bound_load),
        .start_i (loop_start_i),
        .end_i   (loop_end_i),
        .start_q (ls_q),
        .end_q   (le_q)
    );

    lps_next_pc #(.PC_W(PC_W)) u_next (
        .step_i      (step_i),
        .is_jump_i   (is_jump_i),
        .has_dst_i   (jmp_has_dst_i),
        .dst_i       (jmp_dst_i),
        .new_start_i (loop_start_i),
        .pc_q        (pc_q),
        .start_q     (ls_q),
        .end_q       (le_q),
        .src_o       (pc_src),
        .pc_nxt_o    (pc_nxt)
    );

    lps_strobe_regs u_strobes (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step_i),
        .is_jump_i  (is_jump_i),
        .agu_trig_i (agu_trig_i),
        .pred_clr_q (pred_clr_o),
        .agu_step_q (agu_step_o)
    );

    // Purpose: program counter register, cleared to entry 0 on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    // Purpose: expose the counter.
    always_comb pc_o = pc_q;

    // Purpose: the counter must address every configuration entry.
    initial begin
        if (DEPTH != (1 << PC_W)) $error("configuration depth mismatch");
    end

endmodule : loop_pc_sequencer

// File: rtl/lps_checker.sv
// Module: property checker for loop_pc_sequencer, attached with bind.
// Assumes: it observes the top ports and the loop-bound register outputs.
module lps_checker #(
    parameter int unsigned PC_W = lps_pkg::PC_W_DEF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_i,
    input logic            is_jump_i,
    input logic            jmp_has_dst_i,
    input logic [PC_W-1:0] jmp_dst_i,
    input logic [PC_W-1:0] loop_start_i,
    input logic [PC_W-1:0] loop_end_i,
    input logic            agu_trig_i,
    input logic [PC_W-1:0] pc_o,
    input logic            pred_clr_o,
    input logic            agu_step_o,
    input logic [PC_W-1:0] ls_q,
    input logic [PC_W-1:0] le_q
);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pc_o) && !pred_clr_o && !agu_step_o);

    assert_increment_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !is_jump_i && pc_o != le_q) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

    assert_wrap_to_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !is_jump_i && pc_o == le_q) |=> pc_o == $past(ls_q));

    assert_jump_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && is_jump_i && jmp_has_dst_i) |=> pc_o == $past(jmp_dst_i));

    assert_jump_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && is_jump_i && !jmp_has_dst_i) |=> pc_o == $past(loop_start_i));

    assert_bounds_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && is_jump_i) |=> ls_q == $past(loop_start_i) && le_q == $past(loop_end_i));

    assert_pred_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && is_jump_i) |=> pred_clr_o);

    assert_pred_only_after_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_i && is_jump_i) |=> !pred_clr_o);

    assert_agu_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && agu_trig_i) |=> agu_step_o);

    assert_agu_only_after_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_i && agu_trig_i) |=> !agu_step_o);

endmodule : lps_checker

bind loop_pc_sequencer lps_checker #(.PC_W(PC_W)) u_lps_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step_i),
    .is_jump_i     (is_jump_i),
    .jmp_has_dst_i (jmp_has_dst_i),
    .jmp_dst_i     (jmp_dst_i),
    .loop_start_i  (loop_start_i),
    .loop_end_i    (loop_end_i),
    .agu_trig_i    (agu_trig_i),
    .pc_o          (pc_o),
    .pred_clr_o    (pred_clr_o),
    .agu_step_o    (agu_step_o),
    .ls_q          (ls_q),
    .le_q          (le_q)
);

// File: tb/test_loop_pc_sequencer.sv
module test_loop_pc_sequencer;

    localparam int PC_W = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            step_i, is_jump_i, jmp_has_dst_i, agu_trig_i;
    logic [PC_W-1:0] jmp_dst_i, loop_start_i, loop_end_i;
    logic [PC_W-1:0] pc_o;
    logic            pred_clr_o, agu_step_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [PC_W-1:0] m_pc, m_ls, m_le;

    always #5ns clk = ~clk;

    loop_pc_sequencer #(.PC_W(PC_W)) i_loop_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .is_jump_i(is_jump_i),
        .jmp_has_dst_i(jmp_has_dst_i), .jmp_dst_i(jmp_dst_i),
        .loop_start_i(loop_start_i), .loop_end_i(loop_end_i),
        .agu_trig_i(agu_trig_i), .pc_o(pc_o), .pred_clr_o(pred_clr_o),
        .agu_step_o(agu_step_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference next-PC, computed from the requirements.
    function automatic logic [PC_W-1:0] ref_next(input logic s, input logic j,
            input logic h, input logic [PC_W-1:0] d, input logic [PC_W-1:0] st);
        if (!s)           return m_pc;
        if (j)            return h ? d : st;
        if (m_pc == m_le) return m_ls;
        return PC_W'(m_pc + 1);
    endfunction

    // Drives one cycle at a falling edge and checks the outputs one rising edge later.
    task automatic cyc(input logic s, input logic j, input logic h, input logic [PC_W-1:0] d,
                       input logic [PC_W-1:0] st, input logic [PC_W-1:0] en,
                       input logic t, input string tag_in);
        string tag;
        logic [PC_W-1:0] exp_pc;
        if (tag_in != "")       tag = tag_in;
        else if (!s)            tag = "R2";
        else if (j)             tag = h ? "R5" : "R6";
        else if (m_pc == m_le)  tag = "R4";
        else                    tag = "R3";
        step_i = s; is_jump_i = j; jmp_has_dst_i = h; jmp_dst_i = d;
        loop_start_i = st; loop_end_i = en; agu_trig_i = t;
        exp_pc = ref_next(s, j, h, d, st);
        if (s && j) begin m_ls = st; m_le = en; end
        m_pc = exp_pc;
        @(negedge clk);
        chk({tag, " pc"}, int'(pc_o), int'(exp_pc));
        chk("R8 pred_clr", int'(pred_clr_o), int'(s & j));
        chk("R9 agu_step", int'(agu_step_o), int'(s & t));
    endtask

    initial begin
        #1ms;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        step_i = 1'b1; is_jump_i = 1'b1; jmp_has_dst_i = 1'b1; jmp_dst_i = 5'd9;
        loop_start_i = 5'd3; loop_end_i = 5'd7; agu_trig_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", int'(pc_o), 0);
        chk("R1 reset pred_clr", int'(pred_clr_o), 0);
        chk("R1 reset agu_step", int'(agu_step_o), 0);
        rst_n = 1'b1;
        m_pc = '0; m_ls = '0; m_le = '0;
        // R1: stepping from reset stays on entry 0.
        repeat (3) cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R1");
        // R2: a branch without step is ignored, also for the bounds.
        cyc(0, 1, 1, 5'd20, 5'd4, 5'd6, 1, "R2");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R2");
        // R6 then R7: branch without target, run through the new loop twice.
        cyc(1, 1, 0, 5'd30, 5'd4, 5'd6, 1, "R6");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 1, "R3");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R7");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R7");
        chk("R7 wrapped to new start", int'(pc_o), 4);
        // R5 and R3: target beyond loop end wraps modulo 32 through 31 -> 0.
        cyc(1, 1, 1, 5'd30, 5'd1, 5'd2, 0, "R5");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R3");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R3");
        chk("R3 modulo wrap", int'(pc_o), 0);
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R3");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R3");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R4");
        // R4: single-entry loop stays put.
        cyc(1, 1, 0, 5'd0, 5'd12, 5'd12, 0, "R6");
        cyc(1, 0, 0, 5'd0, 5'd0, 5'd0, 1, "R4");
        cyc(0, 0, 0, 5'd0, 5'd0, 5'd0, 1, "R2");
        // Random mix with short loops so wraps are frequent.
        for (int n = 0; n < 3000; n++) begin
            logic s, j, h, t;
            logic [PC_W-1:0] d, st, en;
            s  = ($urandom_range(0, 3) != 0);
            j  = ($urandom_range(0, 7) == 0);
            h  = $urandom_range(0, 1) == 1;
            t  = $urandom_range(0, 1) == 1;
            d  = PC_W'($urandom_range(0, 31));
            st = PC_W'($urandom_range(0, 31));
            en = PC_W'(st + PC_W'($urandom_range(0, 5)));
            cyc(s, j, h, d, st, en, t, "");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule : test_loop_pc_sequencer